// File: doc/BRIEF.md
# Fractional N/M Bit-Clock Enable Divider

This block derives a serial-audio bit clock from a fixed source clock at a rational ratio N/M. A phase accumulator adds 2N on every source cycle. Each time the sum reaches M, M is taken off and the bit-clock output toggles. The toggles therefore come at a long-run rate of 2N/M per source cycle. That gives an average bit-clock frequency of f_src x N / M, where f_src is the source rate. Every output period is a whole number of source cycles, and consecutive periods alternate between two neighbouring lengths. With a 40 MHz source and N=192, M=625, the average is 12.288 MHz, built from periods of 3 and 4 source cycles.

Two outputs come out alongside the bit-clock level. A single-cycle strobe marks each rising bit-clock transition, for logic that runs on the source clock. A flag reports an invalid ratio. N and M are plain inputs and are meant to be set while the block is disabled. Dropping the enable returns the block to its zero phase.

Top module: `fnm_clk_div`

## Requirements
- R1: While reset is held, and on the first sample after it, `bclk_o`, `bclk_stb_o` and `cfg_err_o` are all 0.
- R2: With a valid ratio, after the j-th clock edge at which `en_i` is 1 (counting from a disabled state), `bclk_o` equals bit 0 of floor(j*2N/M).
- R3: `bclk_stb_o` is 1 for exactly those cycles in which `bclk_o` has just changed from 0 to 1, and is 0 otherwise.
- R4: Over the first M enabled cycles, `bclk_stb_o` pulses exactly N times.
- R5: For N=192, M=625, the spacing between consecutive strobes is always 3 or 4 source cycles.
- R6: At the boundary N = M/2, `bclk_o` toggles on every enabled cycle, so the strobe appears every second cycle.
- R7: A ratio is invalid when M = 0 or 2N > M. While it is invalid and `en_i` is 1, `cfg_err_o` is 1 from the next edge on, `bclk_o` keeps its value and `bclk_stb_o` stays 0.
- R8: One edge after `en_i` is sampled at 0, `bclk_o`, `bclk_stb_o` and `cfg_err_o` are 0, and the phase is cleared, so the next enabled run follows R2 again from j=1.
- R9: With N=0, `bclk_o` stays 0 and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Divider enable; 0 clears the phase and forces outputs low |
| ratio_n_i | input | CNT_W | Numerator N |
| ratio_m_i | input | CNT_W | Denominator M |
| bclk_o | output | 1 | Divided bit-clock level |
| bclk_stb_o | output | 1 | One-cycle strobe on each rising bit-clock transition |
| cfg_err_o | output | 1 | Invalid ratio while enabled |

## Verification
The bench builds the block with its default CNT_W of 16. This lets it drive the full-scale ratios of both audio families, including the longest 441/25000 case, and count strobes over a whole M-cycle window. With that width it also covers the N=M/2 boundary, N=0, M=0 and an over-range N. It can further switch to an invalid ratio while the bit clock is high, which shows that the level is held rather than forced low.

// File: rtl/fnm_pkg.sv
package fnm_pkg;
   // Ratio validity: a zero denominator or a step of 2N above M is refused.
   function automatic logic ratio_bad(input logic [31:0] n, input logic [31:0] m);
      return (m == 32'd0) || ((n << 1) > m);
   endfunction
endpackage

// File: rtl/fnm_cfg_check.sv
module fnm_cfg_check #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] n_i,
   input  logic [CNT_W-1:0] m_i,
   output logic             bad_o
);
   localparam int EXT_W = 32 - CNT_W;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 30) else $error("CNT_W out of range");
   end

   always_comb begin
      bad_o = fnm_pkg::ratio_bad({{EXT_W{1'b0}}, n_i}, {{EXT_W{1'b0}}, m_i});
   end
endmodule

// File: rtl/fnm_phase_acc.sv
module fnm_phase_acc #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic             hold_i,
   input  logic [CNT_W-1:0] n_i,
   input  logic [CNT_W-1:0] m_i,
   output logic             wrap_o
);
   localparam int SUM_W = CNT_W + 2;

   logic [CNT_W-1:0] acc_q;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] sum_red;
   logic             over;

   always_comb begin
      sum     = {2'b00, acc_q} + {1'b0, n_i, 1'b0};
      over    = (sum >= {2'b00, m_i});
      sum_red = sum - {2'b00, m_i};
      wrap_o  = en_i && !hold_i && over;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         acc_q <= '0;
      end else if (!hold_i) begin
         acc_q <= over ? sum_red[CNT_W-1:0] : sum[CNT_W-1:0];
      end
   end

   AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && hold_i) |=> (acc_q == $past(acc_q))) else $error("acc moved in hold"); // R7

   AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (acc_q == '0)) else $error("acc not cleared"); // R8
endmodule

// File: rtl/fnm_edge_gen.sv
module fnm_edge_gen (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic bad_i,
   input  logic wrap_i,
   output logic bclk_o,
   output logic stb_o,
   output logic err_o
);
   logic bclk_q, stb_q, err_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         bclk_q <= 1'b0;
         stb_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (bad_i) begin
         stb_q  <= 1'b0;
         err_q  <= 1'b1;
      end else begin
         err_q  <= 1'b0;
         stb_q  <= wrap_i && !bclk_q;
         if (wrap_i) bclk_q <= !bclk_q;
      end
   end

   assign bclk_o = bclk_q;
   assign stb_o  = stb_q;
   assign err_o  = err_q;

   AST_STB_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
      stb_q |-> (bclk_q && !$past(bclk_q))) else $error("strobe without rise"); // R3

   AST_RISE_HAS_STB: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(bclk_q) |-> stb_q) else $error("rise without strobe"); // R3

   AST_ERR_HOLDS_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
      err_q |-> ($stable(bclk_q) && !stb_q)) else $error("output moved under error"); // R7

   AST_OFF_IS_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (!bclk_q && !stb_q && !err_q)) else $error("outputs not low when off"); // R8
endmodule

// File: rtl/fnm_clk_div.sv
module fnm_clk_div #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] ratio_n_i,
   input  logic [CNT_W-1:0] ratio_m_i,
   output logic             bclk_o,
   output logic             bclk_stb_o,
   output logic             cfg_err_o
);
   logic bad;
   logic wrap;

   fnm_cfg_check #(.CNT_W(CNT_W)) u_cfg (
      .n_i   (ratio_n_i),
      .m_i   (ratio_m_i),
      .bad_o (bad)
   );

   fnm_phase_acc #(.CNT_W(CNT_W)) u_acc (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .hold_i (bad),
      .n_i    (ratio_n_i),
      .m_i    (ratio_m_i),
      .wrap_o (wrap)
   );

   fnm_edge_gen u_edge (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .bad_i  (bad),
      .wrap_i (wrap),
      .bclk_o (bclk_o),
      .stb_o  (bclk_stb_o),
      .err_o  (cfg_err_o)
   );
endmodule

// File: tb/fnm_clk_div_tb.sv
module fnm_clk_div_tb_top;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             en  = 1'b0;
   logic [CNT_W-1:0] n_r = '0;
   logic [CNT_W-1:0] m_r = 16'd1;
   logic             bclk, stb, err;

   int tests = 0;
   int fails = 0;

   typedef struct packed { logic bclk; logic stb; logic err; } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   fnm_clk_div #(.CNT_W(CNT_W)) dut_i (
      .clk_i(clk), .rst_i(rst), .en_i(en),
      .ratio_n_i(n_r), .ratio_m_i(m_r),
      .bclk_o(bclk), .bclk_stb_o(stb), .cfg_err_o(err)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Monitor: compares every queued expectation with the outputs (R2 R3 R7)
   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         check("R2 bclk", bclk, e.bclk);
         check("R3 strobe", stb, e.stb);
         check("R7 err", err, e.err);
      end
   end

   function automatic longint steps(input longint j, input longint n, input longint m);
      return (j * 2 * n) / m;
   endfunction

   // Driver: enables from the zero phase, pushes expectations, tallies strobes
   task automatic run_ratio(input int n, input int m, input int cycles,
                            output int stb_cnt, output int min_gap, output int max_gap);
      int last;
      @(negedge clk);
      n_r = CNT_W'(n); m_r = CNT_W'(m); en = 1'b1;
      stb_cnt = 0; min_gap = 1 << 30; max_gap = 0; last = -1;
      for (int j = 1; j <= cycles; j++) begin
         exp_t e;
         longint f0, f1;
         @(posedge clk);
         #1;
         f1 = steps(j, n, m);
         f0 = steps(j - 1, n, m);
         e.bclk = f1[0];
         e.stb  = (f1 != f0) && f1[0];
         e.err  = 1'b0;
         q.push_back(e);
         @(negedge clk);
         #0.1;
         if (stb) begin
            stb_cnt++;
            if (last >= 0) begin
               if (j - last < min_gap) min_gap = j - last;
               if (j - last > max_gap) max_gap = j - last;
            end
            last = j;
         end
      end
   endtask

   task automatic disable_and_check();
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R8 bclk off", bclk, 0);
      check("R8 stb off", stb, 0);
      check("R8 err off", err, 0);
   endtask

   task automatic bad_ratio_check(input int n, input int m, input int hold_level);
      @(negedge clk);
      n_r = CNT_W'(n); m_r = CNT_W'(m);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check("R7 err set", err, 1);
         check("R7 bclk held", bclk, hold_level);
         check("R7 no strobe", stb, 0);
      end
   endtask

   initial begin
      int cnt, gmin, gmax;
      repeat (3) @(negedge clk);
      check("R1 bclk reset", bclk, 0);
      check("R1 stb reset", stb, 0);
      check("R1 err reset", err, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 bclk after reset", bclk, 0);
      check("R1 err after reset", err, 0);

      run_ratio(192, 625, 625, cnt, gmin, gmax);
      check("R4 count 192/625", cnt, 192);
      check("R5 min gap", gmin, 3);
      check("R5 max gap", gmax, 4);
      disable_and_check();

      run_ratio(48, 625, 625, cnt, gmin, gmax);
      check("R4 count 48/625", cnt, 48);
      disable_and_check();

      run_ratio(441, 6250, 6250, cnt, gmin, gmax);
      check("R4 count 441/6250", cnt, 441);
      disable_and_check();

      run_ratio(441, 25000, 25000, cnt, gmin, gmax);
      check("R4 count 441/25000", cnt, 441);
      disable_and_check();

      run_ratio(50, 100, 20, cnt, gmin, gmax);
      check("R6 count half rate", cnt, 10);
      check("R6 gap", gmax, 2);
      check("R6 gap min", gmin, 2);
      disable_and_check();

      run_ratio(0, 625, 100, cnt, gmin, gmax);
      check("R9 no strobe", cnt, 0);
      check("R9 bclk low", bclk, 0);
      disable_and_check();

      // two steps of 192/625: floor(768/625)=1, so bclk is high
      run_ratio(192, 625, 2, cnt, gmin, gmax);
      check("R7 pre level", bclk, 1);
      bad_ratio_check(400, 625, 1);
      bad_ratio_check(5, 0, 1);
      disable_and_check();

      // restart from zero phase after the error
      run_ratio(192, 625, 50, cnt, gmin, gmax);
      check("R8 restart count", cnt, 15);
      disable_and_check();

      repeat (3) @(negedge clk);
      if (q.size() != 0) check("queue drained", q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule